// File: doc/BRIEF.md
# SPI Address Pointer Front End

This block terminates a mode 0 SPI slave link and turns the opcodes that arrive on it into word reads and writes on an internal register/RAM port. Every frame opens with an 8-bit opcode and may be followed by any number of 16-bit words. Most word traffic goes through one of four address pointers. The pointers live inside the block and are reachable themselves at register addresses 0x0B to 0x0E. A 2-bit select field in a 16-bit configuration word decides which pointer is active. One-byte opcodes rewrite that field without touching the rest of the word.

A second path serves "fast" opcodes, which carry a 6-bit register address in their low bits. That address is loaded into a hidden fast pointer, and the four host pointers are left alone. Fast reads are limited to addresses 0x00 to 0x0F. Fast writes are limited to 0x00 to 0x3F. The SPI pins are oversampled in the system clock domain. The internal port uses single-cycle strobes, and read data returns one cycle after the read strobe.

Top module: `spi_ptr_front`

## Requirements
- R1: SPI runs in mode 0 with the most significant bit first. MOSI is sampled on rising SCK and MISO changes on falling SCK. The first 8 bits of a frame form the opcode and the bits after it form 16-bit words. MISO is 0 whenever no read data is being shifted out.
- R2: After reset, cfg_word is 0x0000 and all four pointers are 0. Select bits cfg_word[1:0] = 00 therefore make pointer 1 active. MISO is 0 and no bus strobe is asserted.
- R3: Opcode 0x10 loads all 16 bits of cfg_word from the first word that follows it. Any further words in that frame are ignored.
- R4: Opcodes 0xDB, 0xD8, 0xD9 and 0xDA set cfg_word[1:0] to 00, 01, 10 and 11, which selects pointer 1, 2, 3 and 4. They take no data and leave cfg_word[15:2] unchanged.
- R5: Opcode 0x20 returns words on MISO, starting at the address held in the active pointer. The pointer advances by one after each word.
- R6: Opcode 0x30 writes each received word to the address in the active pointer and then advances that pointer by one.
- R7: Addresses 0x0B, 0x0C, 0x0D and 0x0E are pointers 1 to 4. A read or write to one of them, on either path, is served inside the block and raises no bus strobe.
- R8: Opcodes 0x40 to 0x7F are fast writes to address opcode[5:0]. The fast pointer advances after each word, and words aimed above 0x3F are dropped. Loading the fast pointer leaves pointers 1 to 4 unchanged.
- R9: Opcodes 0x80 to 0xBF are fast reads from address opcode[5:0], with the fast pointer advancing after each word. A word whose address is above 0x0F is rejected: it raises no bus_rd and shifts out zeros. No opcode returns the fast pointer itself.
- R10: Raising CS_n before a word is complete aborts the frame. The partial word is not written and no pointer moves.
- R11: Any other opcode (for example 0x00 or 0xFF) is ignored together with the rest of its frame. It raises no strobe, leaves cfg_word unchanged and shifts out zeros. bus_rd and bus_wr are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled on it |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock (idle low) |
| spi_mosi | input | 1 | SPI data from host |
| spi_cs_n | input | 1 | SPI frame select, active low |
| spi_miso | output | 1 | SPI data to host |
| bus_addr | output | 16 | Internal port word address |
| bus_rd | output | 1 | Internal port read strobe, one cycle |
| bus_wr | output | 1 | Internal port write strobe, one cycle |
| bus_wdata | output | 16 | Internal port write data |
| bus_rdata | input | 16 | Internal port read data, valid the cycle after bus_rd |
| cfg_word | output | 16 | Configuration word; bits [1:0] select the active pointer |

## Verification
The hardest case to reach from the ports is a fast read that starts inside the readable window and then walks past 0x0F in the same frame. The second word must come back as zeros with no bus read behind it. The bench gets there by opening a fast read at 0x0F and clocking two words, while it counts read strobes on its model of the bus. The same approach of counting bus writes covers a fast write that crosses 0x3F and a frame cut off after ten data bits. The pointer values are then read back through the fast path at 0x0B to 0x0E.

// File: rtl/spi_ptr_pkg.sv
package spi_ptr_pkg;

  typedef enum logic [2:0] {
    MD_IDLE, MD_CFG, MD_PRD, MD_PWR, MD_FRD, MD_FWR, MD_DROP
  } md_t;

  localparam logic [7:0] OP_CFG    = 8'h10;
  localparam logic [7:0] OP_PRD    = 8'h20;
  localparam logic [7:0] OP_PWR    = 8'h30;
  localparam logic [5:0] SEL_GROUP = 6'b110110;
  localparam logic [1:0] FW_TAG    = 2'b01;
  localparam logic [1:0] FR_TAG    = 2'b10;

  typedef struct packed {
    md_t        mode;
    logic       sel_wr;
    logic [1:0] sel;
    logic       fast_ld;
    logic       rd_go;
  } dec_t;

  // Opcode decode. The select group maps low bits 11,00,01,10 to select 00,01,10,11.
  function automatic dec_t decode_op(input logic [7:0] op);
    dec_t d;
    d = '0;
    d.mode = MD_DROP;
    if (op == OP_CFG) begin
      d.mode = MD_CFG;
    end else if (op == OP_PRD) begin
      d.mode  = MD_PRD;
      d.rd_go = 1'b1;
    end else if (op == OP_PWR) begin
      d.mode = MD_PWR;
    end else if (op[7:2] == SEL_GROUP) begin
      d.sel_wr = 1'b1;
      d.sel    = op[1:0] + 2'd1;
    end else if (op[7:6] == FW_TAG) begin
      d.mode    = MD_FWR;
      d.fast_ld = 1'b1;
    end else if (op[7:6] == FR_TAG) begin
      d.mode    = MD_FRD;
      d.fast_ld = 1'b1;
      d.rd_go   = 1'b1;
    end
    return d;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic csn_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic cs_act
);
  // bit 2 = cs_n, bit 1 = mosi, bit 0 = sck
  logic [STAGES-1:0][2:0] stg;
  logic                   sck_d;
  logic [2:0]             last;

  assign last = stg[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= 3'b100;
      sck_d <= 1'b0;
    end else begin
      stg[0] <= {csn_i, mosi_i, sck_i};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sck_d <= last[0];
    end
  end

  assign cs_act   = ~last[2];
  assign mosi_s   = last[1];
  assign sck_rise = cs_act &  last[0] & ~sck_d;
  assign sck_fall = cs_act & ~last[0] &  sck_d;
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int DW  = 16,
  parameter int OPW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_s,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_val,
  output logic          op_done,
  output logic          word_done,
  output logic [DW-1:0] rx_next,
  output logic          miso
);
  localparam int CW = $clog2(DW);

  logic [CW-1:0] cnt;
  logic          in_op;
  logic [DW-1:0] rx_sr;
  logic [DW-1:0] tx_sr;

  assign rx_next   = {rx_sr[DW-2:0], mosi_s};
  assign op_done   = sck_rise &  in_op && (cnt == CW'(OPW - 1));
  assign word_done = sck_rise && !in_op && (cnt == CW'(DW - 1));

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      cnt   <= '0;
      in_op <= 1'b1;
      rx_sr <= '0;
    end else if (sck_rise) begin
      rx_sr <= rx_next;
      if (op_done || word_done) begin
        cnt   <= '0;
        in_op <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      tx_sr <= '0;
      miso  <= 1'b0;
    end else if (tx_load) begin
      tx_sr <= tx_val;
    end else if (sck_fall) begin
      miso  <= tx_sr[DW-1];
      tx_sr <= {tx_sr[DW-2:0], 1'b0};
    end
  end

  // R1
  no_double_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |=> !word_done);
endmodule

// File: rtl/spi_ptr_bank.sv
module spi_ptr_bank #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int NPTR = 4,
  parameter int SW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [DW-1:0] cfg_val,
  input  logic          sel_wr,
  input  logic [SW-1:0] sel_val,
  input  logic          ptr_wr,
  input  logic [SW-1:0] ptr_wr_idx,
  input  logic [AW-1:0] ptr_wr_val,
  input  logic          inc_act,
  input  logic          fast_load,
  input  logic [AW-1:0] fast_val,
  input  logic          inc_fast,
  input  logic [SW-1:0] rd_idx,
  output logic [DW-1:0] cfg_q,
  output logic [AW-1:0] act_ptr,
  output logic [AW-1:0] fast_ptr,
  output logic [AW-1:0] ptr_rd_val
);
  logic [AW-1:0]      ptr_q  [NPTR];
  logic [AW-1:0]      ptr_nx [NPTR];
  logic [NPTR*AW-1:0] ptr_flat;
  logic [SW-1:0]      sel_q;

  assign sel_q = cfg_q[SW-1:0];

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    assign ptr_nx[g] = (ptr_wr && ptr_wr_idx == SW'(g)) ? ptr_wr_val :
                       (inc_act && sel_q == SW'(g))     ? ptr_q[g] + AW'(1) :
                                                          ptr_q[g];
    assign ptr_flat[g*AW +: AW] = ptr_q[g];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPTR; i++) ptr_q[i] <= rst ? '0 : ptr_nx[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_wr) begin
      cfg_q <= cfg_val;
    end else if (sel_wr) begin
      cfg_q[SW-1:0] <= sel_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            fast_ptr <= '0;
    else if (fast_load) fast_ptr <= fast_val;
    else if (inc_fast)  fast_ptr <= fast_ptr + AW'(1);
  end

  assign act_ptr    = ptr_q[sel_q];
  assign ptr_rd_val = ptr_q[rd_idx];

  // R2
  sel_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg_q[SW-1:0] == '0));
  // R4
  sel_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_wr && !cfg_wr) |=> ($stable(cfg_q[DW-1:SW]) && cfg_q[SW-1:0] == $past(sel_val)));
  // R8
  fast_keeps_ptrs_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_load && !ptr_wr && !inc_act) |=> $stable(ptr_flat));
  // R5
  act_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_act && !ptr_wr && !sel_wr && !cfg_wr) |=> (act_ptr == $past(act_ptr) + AW'(1)));
endmodule

// File: rtl/spi_ptr_front.sv
module spi_ptr_front
  import spi_ptr_pkg::*;
#(
  parameter int DW          = 16,
  parameter int AW          = 16,
  parameter int OPW         = 8,
  parameter int SYNC        = 2,
  parameter int NPTR        = 4,
  parameter int PTR_BASE    = 11,
  parameter int FAST_AW     = 6,
  parameter int FAST_RD_MAX = 15,
  parameter int FAST_WR_MAX = 63
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  input  logic          spi_cs_n,
  output logic          spi_miso,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] cfg_word
);
  localparam int SW = $clog2(NPTR);

  logic          sck_rise, sck_fall, mosi_s, cs_act;
  logic          op_done, word_done;
  logic [DW-1:0] rx_next;
  logic          tx_load;
  logic [DW-1:0] tx_val;

  spi_pin_sync #(.STAGES(SYNC)) sync_i (
    .clk(clk), .rst(rst), .sck_i(spi_sck), .mosi_i(spi_mosi), .csn_i(spi_cs_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s), .cs_act(cs_act)
  );

  spi_bit_shifter #(.DW(DW), .OPW(OPW)) shift_i (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi_s(mosi_s), .tx_load(tx_load), .tx_val(tx_val), .op_done(op_done),
    .word_done(word_done), .rx_next(rx_next), .miso(spi_miso)
  );

  // Frame control
  md_t           mode_q;
  logic          rd_req, wr_req, req_fast;
  logic [DW-1:0] wdata_q;
  dec_t          dec;
  logic [7:0]    op_byte;
  logic          mode_fast;

  assign op_byte   = rx_next[7:0];
  assign dec       = decode_op(op_byte);
  assign mode_fast = (mode_q == MD_FRD) || (mode_q == MD_FWR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MD_IDLE;
      rd_req   <= 1'b0;
      wr_req   <= 1'b0;
      req_fast <= 1'b0;
      wdata_q  <= '0;
    end else begin
      rd_req <= 1'b0;
      wr_req <= 1'b0;
      if (!cs_act) begin
        mode_q <= MD_IDLE;
      end else if (op_done) begin
        mode_q   <= dec.mode;
        rd_req   <= dec.rd_go;
        req_fast <= dec.fast_ld;
      end else if (word_done) begin
        case (mode_q)
          MD_CFG: mode_q <= MD_DROP;
          MD_PRD, MD_FRD: begin
            rd_req   <= 1'b1;
            req_fast <= mode_fast;
          end
          MD_PWR, MD_FWR: begin
            wr_req   <= 1'b1;
            req_fast <= mode_fast;
            wdata_q  <= rx_next;
          end
          default: ;
        endcase
      end
    end
  end

  // Pointer bank
  logic [AW-1:0] act_ptr, fast_ptr, ptr_rd_val, acc_ptr;
  logic [SW-1:0] acc_idx;
  logic          acc_hit, rd_ok, wr_ok;

  assign acc_ptr = req_fast ? fast_ptr : act_ptr;
  assign acc_hit = (acc_ptr >= AW'(PTR_BASE)) && (acc_ptr <= AW'(PTR_BASE + NPTR - 1));
  assign acc_idx = SW'(acc_ptr - AW'(PTR_BASE));
  assign rd_ok   = !req_fast || (acc_ptr <= AW'(FAST_RD_MAX));
  assign wr_ok   = !req_fast || (acc_ptr <= AW'(FAST_WR_MAX));

  spi_ptr_bank #(.AW(AW), .DW(DW), .NPTR(NPTR), .SW(SW)) bank_i (
    .clk(clk), .rst(rst),
    .cfg_wr(word_done && mode_q == MD_CFG), .cfg_val(rx_next),
    .sel_wr(op_done && dec.sel_wr), .sel_val(SW'(dec.sel)),
    .ptr_wr(wr_req && wr_ok && acc_hit), .ptr_wr_idx(acc_idx), .ptr_wr_val(AW'(wdata_q)),
    .inc_act((word_done && mode_q == MD_PRD) || (wr_req && !req_fast)),
    .fast_load(op_done && dec.fast_ld), .fast_val(AW'(op_byte[FAST_AW-1:0])),
    .inc_fast((word_done && mode_q == MD_FRD) || (wr_req && req_fast)),
    .rd_idx(acc_idx), .cfg_q(cfg_word), .act_ptr(act_ptr), .fast_ptr(fast_ptr),
    .ptr_rd_val(ptr_rd_val)
  );

  // Bus port and read return
  logic          bus_fast_q;
  logic          ld_p1, ld_p2, int_p1, int_p2, zero_p1, zero_p2;
  logic [DW-1:0] int_d1, int_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd     <= 1'b0;
      bus_wr     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      bus_fast_q <= 1'b0;
      {ld_p1, ld_p2, int_p1, int_p2, zero_p1, zero_p2} <= '0;
      int_d1     <= '0;
      int_d2     <= '0;
    end else begin
      bus_rd <= rd_req && rd_ok && !acc_hit;
      bus_wr <= wr_req && wr_ok && !acc_hit;
      if (rd_req || wr_req) begin
        bus_addr   <= acc_ptr;
        bus_fast_q <= req_fast;
      end
      if (wr_req) bus_wdata <= wdata_q;
      ld_p1   <= rd_req;
      int_p1  <= acc_hit;
      zero_p1 <= !rd_ok;
      int_d1  <= DW'(ptr_rd_val);
      ld_p2   <= ld_p1;
      int_p2  <= int_p1;
      zero_p2 <= zero_p1;
      int_d2  <= int_d1;
    end
  end

  assign tx_load = ld_p2;
  assign tx_val  = zero_p2 ? '0 : (int_p2 ? int_d2 : bus_rdata);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_rd, bus_wr}));
  // R9
  fast_rd_range_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_fast_q) |-> (bus_addr <= AW'(FAST_RD_MAX)));
  // R8
  fast_wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_fast_q) |-> (bus_addr <= AW'(FAST_WR_MAX)));
  // R7
  ptr_off_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |->
      !((bus_addr >= AW'(PTR_BASE)) && (bus_addr <= AW'(PTR_BASE + NPTR - 1))));
endmodule

// File: tb/spi_ptr_front_tb.sv
module spi_ptr_front_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso, bus_rd, bus_wr;
  logic [15:0] bus_addr, bus_wdata, cfg_word;
  logic [15:0] bus_rdata = 16'h0;

  spi_ptr_front dut_i (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .spi_miso(miso), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_word(cfg_word)
  );

  // Bus model: 64 words, registered read
  logic [15:0] mem [64];
  int wr_cnt = 0, rd_cnt = 0;
  initial for (int i = 0; i < 64; i++) mem[i] = 16'h1000 + 16'(i * 3);
  always @(posedge clk) begin
    if (bus_wr) begin
      mem[bus_addr[5:0]] <= bus_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (bus_rd) begin
      bus_rdata <= mem[bus_addr[5:0]];
      rd_cnt <= rd_cnt + 1;
    end
  end

  int checks = 0, errors = 0;
  logic [15:0] txw [4];
  logic [15:0] rxw [4];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] v, input int n, output logic [15:0] r);
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      repeat (HALF) @(negedge clk);
      r = {r[14:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [7:0] op, input int nw);
    logic [15:0] dummy;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    xfer({8'h00, op}, 8, dummy);
    for (int k = 0; k < nw; k++) xfer(txw[k], 16, rxw[k]);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic abort_frame(input logic [7:0] op, input int nbits);
    logic [15:0] dummy;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    xfer({8'h00, op}, 8, dummy);
    xfer(16'hFFFF, nbits, dummy);
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic one(input logic [7:0] op, input logic [15:0] w);
    txw[0] = w;
    frame(op, 1);
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // kind[41:40] op[39:32] word[31:16] expect[15:0]
  // kind 0: cfg after one word, 1: MISO word check, 2: write only, 3: cfg after opcode only
  localparam logic [41:0] VEC [12] = '{
    {2'd0, 8'h10, 16'h1234, 16'h1234},
    {2'd3, 8'hD9, 16'h0000, 16'h1236},
    {2'd3, 8'hD8, 16'h0000, 16'h1235},
    {2'd3, 8'hDA, 16'h0000, 16'h1237},
    {2'd3, 8'hDB, 16'h0000, 16'h1234},
    {2'd2, 8'h4B, 16'h0020, 16'h0000},
    {2'd1, 8'h8B, 16'h0000, 16'h0020},
    {2'd2, 8'h30, 16'hBEEF, 16'h0000},
    {2'd1, 8'h8B, 16'h0000, 16'h0021},
    {2'd2, 8'h5A, 16'hCAFE, 16'h0000},
    {2'd1, 8'h9A, 16'h0000, 16'h0000},
    {2'd1, 8'h85, 16'h0000, 16'h100F}
  };

  function automatic string vec_req(input int i);
    case (i)
      0:          return "R3 cfg load";
      1, 2, 3, 4: return "R4 select opcode";
      6:          return "R7 pointer read via fast path";
      8:          return "R6 pointer advanced by write";
      10:         return "R9 fast read above 0x0F rejected";
      11:         return "R1 R9 fast read in range, MSB first";
      default:    return "none";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    int wsnap, rsnap;
    logic [15:0] csnap;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R2 reset state
    chk("R2 cfg_word after reset", cfg_word, 16'h0000);
    chk("R2 miso after reset", {15'd0, miso}, 16'h0000);
    chk("R2 strobes after reset", {14'd0, bus_rd, bus_wr}, 16'h0000);
    // R2 pointer 1 active from reset: load it with 7, read one word
    one(8'h4B, 16'h0007);
    one(8'h20, 16'h0000);
    chk("R2 reset selects pointer 1", rxw[0], 16'h1015);

    // Vector table
    for (int i = 0; i < 12; i++) begin
      logic [1:0] kind;
      kind = VEC[i][41:40];
      if (kind == 2'd3) frame(VEC[i][39:32], 0);
      else one(VEC[i][39:32], VEC[i][31:16]);
      if (kind == 2'd0 || kind == 2'd3) chk(vec_req(i), cfg_word, VEC[i][15:0]);
      else if (kind == 2'd1) chk(vec_req(i), rxw[0], VEC[i][15:0]);
    end

    // R6 / R5 multi-word burst through pointer 2
    one(8'h4C, 16'h0030);
    frame(8'hD8, 0);
    txw[0] = 16'h1111; txw[1] = 16'h2222; txw[2] = 16'h3333;
    frame(8'h30, 3);
    one(8'h8C, 16'h0000);
    chk("R6 pointer 2 after 3-word write", rxw[0], 16'h0033);
    one(8'h4C, 16'h0030);
    txw[0] = 16'h0; txw[1] = 16'h0; txw[2] = 16'h0;
    frame(8'h20, 3);
    chk("R5 burst word 0", rxw[0], 16'h1111);
    chk("R5 burst word 1", rxw[1], 16'h2222);
    chk("R5 burst word 2", rxw[2], 16'h3333);
    one(8'h8C, 16'h0000);
    chk("R5 pointer 2 after 3-word read", rxw[0], 16'h0033);

    // R6 earlier pointer write landed; R8 fast write landed
    frame(8'hDB, 0);
    one(8'h4B, 16'h0020);
    one(8'h20, 16'h0000);
    chk("R6 word written via pointer 1", rxw[0], 16'hBEEF);
    one(8'h4D, 16'h001A);
    frame(8'hD9, 0);
    one(8'h20, 16'h0000);
    chk("R8 word written by fast write", rxw[0], 16'hCAFE);

    // R8 fast opcodes leave pointers alone
    one(8'h9F, 16'h0000);
    one(8'h81, 16'h0000);
    one(8'h8B, 16'h0000);
    chk("R8 pointer 1 unchanged by fast ops", rxw[0], 16'h0021);

    // R10 abort mid-word: pointer 3 (0x1B) active
    wsnap = wr_cnt;
    abort_frame(8'h30, 10);
    chk("R10 no bus write on abort", 16'(wr_cnt - wsnap), 16'h0000);
    one(8'h8D, 16'h0000);
    chk("R10 pointer 3 unchanged by abort", rxw[0], 16'h001B);

    // R11 unknown opcodes
    wsnap = wr_cnt; rsnap = rd_cnt; csnap = cfg_word;
    one(8'h00, 16'hFFFF);
    chk("R11 miso zero on unknown opcode", rxw[0], 16'h0000);
    one(8'hFF, 16'hFFFF);
    chk("R11 no write strobe", 16'(wr_cnt - wsnap), 16'h0000);
    chk("R11 no read strobe", 16'(rd_cnt - rsnap), 16'h0000);
    chk("R11 cfg unchanged", cfg_word, csnap);

    // R3 extra words ignored
    txw[0] = 16'hA5A4; txw[1] = 16'h0F0F;
    frame(8'h10, 2);
    chk("R3 only first word loads cfg", cfg_word, 16'hA5A4);

    // R9 fast read walking past 0x0F
    rsnap = rd_cnt;
    txw[0] = 16'h0; txw[1] = 16'h0;
    frame(8'h8F, 2);
    chk("R9 last readable fast address", rxw[0], 16'h102D);
    chk("R9 word past 0x0F returns zero", rxw[1], 16'h0000);
    chk("R9 one bus read only", 16'(rd_cnt - rsnap), 16'h0001);

    // R8 fast write walking past 0x3F
    wsnap = wr_cnt;
    txw[0] = 16'h7777; txw[1] = 16'h8888;
    frame(8'h7F, 2);
    chk("R8 one bus write below limit", 16'(wr_cnt - wsnap), 16'h0001);
    chk("R8 word at 0x3F", mem[63], 16'h7777);

    report();
  end
endmodule